// File: doc/BRIEF.md
# Error-Tolerant Sync Word Detector

The block hunts for a programmable synchronisation pattern in a stream of raw received bits, one bit for each cycle in which a bit-enable is high. The comparison window holds the most recent 12, 16, 20 or 24 bits, chosen by a length select. The window is accepted when its Hamming distance to the pattern is no greater than a programmable tolerance of 0 to 3. The pattern sits ahead of the coded payload and has no error-correction cover, so this tolerance is what keeps a few corrupted preamble bits from costing the whole packet.

On acceptance the block gives a single-cycle packet-start strobe that the downstream decoder uses to begin work. It also raises a lock flag that stays high until the next arm. A watchdog counts bit-enable cycles once hunting is armed. If no match arrives within the programmed number of bits, it gives a substitute packet-start strobe, marked as such. After either kind of start the block stops hunting until it is armed again, so payload bits cannot produce a second start.

Top module: `syncdet_top`

## Requirements
- R1: After reset, frameStart, timeoutPulse, lockFlag, viaTimeout and hunting are all 0.
- R2: A one-cycle arm pulse makes hunting 1 and clears lockFlag and viaTimeout from the next cycle on. It also restarts the watchdog count and the received-bit count.
- R3: The most recently received bit is compared with pattern bit 0, and the bit received N-1 bits earlier with bit N-1. When the window matches, frameStart is high for the cycle after the clock edge that took the qualifying bit. In that same cycle lockFlag becomes 1, viaTimeout is 0 and hunting is 0.
- R4: lenSel values 0, 1, 2 and 3 select N = 12, 16, 20 and 24. Pattern bits at or above N, and bits received before the window, have no effect.
- R5: A window with at most errLimit mismatching bits (errLimit 0 to 3) is accepted. A window with errLimit+1 mismatches is not accepted.
- R6: A match is accepted only once at least N bits have been received since the last arm. Bits held from before the arm never complete a match.
- R7: After a packet start, whether from a match or a timeout, no further frameStart occurs until the next arm.
- R8: frameStart and timeoutPulse are each high for exactly one clock cycle.
- R9: Suppose timeoutBits = T > 0 and the T-th bit-enable cycle after arm brings no match. Then frameStart and timeoutPulse are both high in the following cycle, viaTimeout becomes 1, lockFlag stays 0 and hunting drops. Cycles without bit-enable are not counted.
- R10: With timeoutBits = 0 the watchdog never fires.
- R11: When the bit that reaches the timeout also completes a match, the real match wins: lockFlag is 1, viaTimeout is 0 and timeoutPulse is 0.
- R12: lockFlag holds at 1 until the next arm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitValid | input | 1 | Bit-enable: bitIn is taken this cycle |
| bitIn | input | 1 | Received demodulated bit |
| syncPattern | input | 24 | Pattern; bit 0 is the last bit received |
| lenSel | input | 2 | Window length select (12/16/20/24) |
| errLimit | input | 2 | Largest accepted number of mismatches |
| timeoutBits | input | 16 | Watchdog limit in bits; 0 disables it |
| arm | input | 1 | Start or restart the hunt |
| frameStart | output | 1 | One-cycle packet-start strobe |
| timeoutPulse | output | 1 | One-cycle strobe when the start came from the watchdog |
| lockFlag | output | 1 | Level: a real match was found |
| viaTimeout | output | 1 | Level: the last start came from the watchdog |
| hunting | output | 1 | Level: armed and searching |

## Verification
Exact patterns are sent at all four lengths with junk bits ahead of the window. This separates correct masking and bit ordering from a comparison that uses bits outside the window. Patterns with as many flipped bits as errLimit allows, and with one more, show whether the tolerance boundary is inclusive and off by none. An all-ones pattern re-sent right after a re-arm shows whether stale history can complete a match. Runs of non-matching bits with idle gaps cover the watchdog: they show whether it counts only bit-enable cycles, fires on exactly the T-th bit, stays silent when disabled, and gives way to a real match on the same bit.

// File: rtl/syncdet_pkg.sv
package syncdet_pkg;
  // Window lengths are MIN_LEN + LEN_STEP * lenSel
  localparam int unsigned MIN_LEN  = 12;
  localparam int unsigned LEN_STEP = 4;

  // Strobes from control into the datapath
  typedef struct packed {
    logic restart;  // clear bit and watchdog counts
    logic hunting;  // counting enabled
  } dpCtl_t;
endpackage

// File: rtl/syncdet_datapath.sv
module syncdet_datapath
  import syncdet_pkg::*;
#(
  parameter int unsigned MAX_LEN = 24,
  parameter int unsigned SEL_W   = 2,
  parameter int unsigned ERR_W   = 2,
  parameter int unsigned TMO_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpCtl_t             ctl,
  input  logic               bitValid,
  input  logic               bitIn,
  input  logic [MAX_LEN-1:0] syncPattern,
  input  logic [SEL_W-1:0]   lenSel,
  input  logic [ERR_W-1:0]   errLimit,
  input  logic [TMO_W-1:0]   timeoutBits,
  output logic               matchHit,
  output logic               wdogExpire
);
  localparam int unsigned CNT_W = $clog2(MAX_LEN + 1);

  logic [MAX_LEN-1:0] shiftQ, shiftNext, winMask, diffBits;
  logic [CNT_W-1:0]   fillQ, lenBits, errCount;
  logic [CNT_W:0]     fillInc;
  logic [TMO_W-1:0]   wdogQ;
  logic [TMO_W:0]     wdogInc;
  logic               windowFull, takeBit;

  assign takeBit   = bitValid && ctl.hunting && !ctl.restart;
  assign shiftNext = {shiftQ[MAX_LEN-2:0], bitIn};
  assign lenBits   = CNT_W'(MIN_LEN + LEN_STEP * int'(lenSel));
  assign fillInc   = {1'b0, fillQ} + 1'b1;
  assign wdogInc   = {1'b0, wdogQ} + 1'b1;

  // Window mask and mismatch population count
  always_comb begin
    errCount = '0;
    for (int i = 0; i < MAX_LEN; i++) begin
      winMask[i]  = (CNT_W'(i) < lenBits);
      diffBits[i] = (shiftNext[i] ^ syncPattern[i]) & winMask[i];
      errCount    = errCount + CNT_W'(diffBits[i]);
    end
  end

  assign windowFull = (fillInc >= {1'b0, lenBits});
  assign matchHit   = takeBit && windowFull &&
                      (errCount <= CNT_W'(errLimit));
  assign wdogExpire = takeBit && (timeoutBits != '0) &&
                      (wdogInc == {1'b0, timeoutBits});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '0;
    end else if (bitValid) begin
      shiftQ <= shiftNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fillQ <= '0;
      wdogQ <= '0;
    end else if (ctl.restart) begin
      fillQ <= '0;
      wdogQ <= '0;
    end else if (takeBit) begin
      if (fillQ < CNT_W'(MAX_LEN)) fillQ <= fillInc[CNT_W-1:0];
      wdogQ <= wdogInc[TMO_W-1:0];
    end
  end
endmodule

// File: rtl/syncdet_control.sv
module syncdet_control
  import syncdet_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   arm,
  input  logic   matchHit,
  input  logic   wdogExpire,
  output dpCtl_t ctl,
  output logic   frameStart,
  output logic   timeoutPulse,
  output logic   lockFlag,
  output logic   viaTimeout,
  output logic   hunting
);
  assign ctl.restart = arm;
  assign ctl.hunting = hunting;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hunting      <= 1'b0;
      frameStart   <= 1'b0;
      timeoutPulse <= 1'b0;
      lockFlag     <= 1'b0;
      viaTimeout   <= 1'b0;
    end else begin
      frameStart   <= 1'b0;
      timeoutPulse <= 1'b0;
      if (arm) begin
        hunting    <= 1'b1;
        lockFlag   <= 1'b0;
        viaTimeout <= 1'b0;
      end else if (hunting && matchHit) begin
        hunting    <= 1'b0;
        frameStart <= 1'b1;
        lockFlag   <= 1'b1;
        viaTimeout <= 1'b0;
      end else if (hunting && wdogExpire) begin
        hunting      <= 1'b0;
        frameStart   <= 1'b1;
        timeoutPulse <= 1'b1;
        viaTimeout   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/syncdet_top.sv
module syncdet_top
  import syncdet_pkg::*;
#(
  parameter int unsigned MAX_LEN = 24,
  parameter int unsigned SEL_W   = 2,
  parameter int unsigned ERR_W   = 2,
  parameter int unsigned TMO_W   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               bitValid,
  input  logic               bitIn,
  input  logic [MAX_LEN-1:0] syncPattern,
  input  logic [SEL_W-1:0]   lenSel,
  input  logic [ERR_W-1:0]   errLimit,
  input  logic [TMO_W-1:0]   timeoutBits,
  input  logic               arm,
  output logic               frameStart,
  output logic               timeoutPulse,
  output logic               lockFlag,
  output logic               viaTimeout,
  output logic               hunting
);
  dpCtl_t ctl;
  logic   matchHit, wdogExpire;

  syncdet_datapath #(
    .MAX_LEN(MAX_LEN), .SEL_W(SEL_W), .ERR_W(ERR_W), .TMO_W(TMO_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .bitValid(bitValid), .bitIn(bitIn),
    .syncPattern(syncPattern), .lenSel(lenSel),
    .errLimit(errLimit), .timeoutBits(timeoutBits),
    .matchHit(matchHit), .wdogExpire(wdogExpire)
  );

  syncdet_control u_ctl (
    .clk(clk), .rstN(rstN), .arm(arm),
    .matchHit(matchHit), .wdogExpire(wdogExpire), .ctl(ctl),
    .frameStart(frameStart), .timeoutPulse(timeoutPulse),
    .lockFlag(lockFlag), .viaTimeout(viaTimeout), .hunting(hunting)
  );
endmodule

// File: rtl/syncdet_checker.sv
module syncdet_checker (
  input logic clk,
  input logic rstN,
  input logic bitValid,
  input logic arm,
  input logic frameStart,
  input logic timeoutPulse,
  input logic lockFlag,
  input logic viaTimeout,
  input logic hunting
);
  assert_one_cycle_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> !frameStart);

  assert_tmo_one_cycle_R8: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |=> !timeoutPulse);

  assert_stop_after_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |-> !hunting);

  assert_timeout_tags_R9: assert property (@(posedge clk) disable iff (!rstN)
    timeoutPulse |-> (frameStart && viaTimeout && !lockFlag));

  assert_match_locks_R3: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && !timeoutPulse) |-> (lockFlag && !viaTimeout));

  assert_start_needs_bit_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frameStart) |-> ($past(bitValid) && $past(hunting)));

  assert_lock_holds_R12: assert property (@(posedge clk) disable iff (!rstN)
    (lockFlag && !arm) |=> lockFlag);

  assert_arm_hunts_R2: assert property (@(posedge clk) disable iff (!rstN)
    arm |=> (hunting && !lockFlag && !viaTimeout && !frameStart));
endmodule

bind syncdet_top syncdet_checker u_chk (
  .clk(clk), .rstN(rstN), .bitValid(bitValid), .arm(arm),
  .frameStart(frameStart), .timeoutPulse(timeoutPulse),
  .lockFlag(lockFlag), .viaTimeout(viaTimeout), .hunting(hunting)
);

// File: tb/syncdet_top_tb.sv
module syncdet_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitValid = 1'b0;
  logic        bitIn = 1'b0;
  logic [23:0] syncPattern = '0;
  logic [1:0]  lenSel = '0;
  logic [1:0]  errLimit = '0;
  logic [15:0] timeoutBits = '0;
  logic        arm = 1'b0;
  logic        frameStart, timeoutPulse, lockFlag, viaTimeout, hunting;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  syncdet_top u_dut (
    .clk(clk), .rstN(rstN), .bitValid(bitValid), .bitIn(bitIn),
    .syncPattern(syncPattern), .lenSel(lenSel), .errLimit(errLimit),
    .timeoutBits(timeoutBits), .arm(arm), .frameStart(frameStart),
    .timeoutPulse(timeoutPulse), .lockFlag(lockFlag),
    .viaTimeout(viaTimeout), .hunting(hunting)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doArm();
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
  endtask

  // Drive one bit; sample strobes in the cycle after the taking edge
  task automatic sendBit(input bit b, output bit st, output bit tp);
    @(negedge clk); bitValid = 1'b1; bitIn = b;
    @(negedge clk); bitValid = 1'b0;
    st = frameStart; tp = timeoutPulse;
  endtask

  // Send w[n-1] first down to w[0]; flips inverts chosen bits
  task automatic sendWord(input logic [23:0] w, input int n, input logic [23:0] flips,
                          output int early, output bit lastSt, output bit lastTp);
    bit st, tp;
    early = 0; lastSt = 0; lastTp = 0;
    for (int i = n - 1; i >= 0; i--) begin
      sendBit(w[i] ^ flips[i], st, tp);
      if (i != 0) early += int'(st);
      else begin lastSt = st; lastTp = tp; end
    end
  endtask

  task automatic t_reset();
    check({frameStart, timeoutPulse, lockFlag, viaTimeout, hunting} == 5'b0,
          "R1 reset outputs", int'({frameStart, timeoutPulse, lockFlag, viaTimeout, hunting}), 0);
  endtask

  task automatic t_lengths();
    int early; bit st, tp, dummy;
    for (int L = 0; L < 4; L++) begin
      int n;
      n = 12 + 4 * L;
      lenSel = 2'(L); errLimit = 0; timeoutBits = 0;
      syncPattern = 24'h5A3C96 ^ (24'hFFFFFF << n);  // bits above N are junk (R4)
      doArm();
      check(hunting == 1'b1 && lockFlag == 1'b0, "R2 arm hunting", int'(hunting), 1);
      for (int j = 0; j < 3; j++) sendBit(j[0], dummy, tp);   // junk before window (R4)
      sendWord(syncPattern, n, 24'h0, early, st, tp);
      check(early == 0, "R4 no early start", early, 0);
      check(st == 1'b1 && tp == 1'b0, "R3 start after last bit", int'(st), 1);
      check(lockFlag && !viaTimeout && !hunting, "R3 lock set",
            int'({lockFlag, viaTimeout, hunting}), 4);
      @(negedge clk);
      check(frameStart == 1'b0, "R8 one-cycle strobe", int'(frameStart), 0);
    end
  endtask

  task automatic t_tolerance();
    int early; bit st, tp;
    lenSel = 2'd1; timeoutBits = 0; syncPattern = 24'h00C3A5;
    errLimit = 2'd2; doArm();
    sendWord(syncPattern, 16, 24'h000101, early, st, tp);
    check(st == 1'b1, "R5 two errors accepted at limit 2", int'(st), 1);
    doArm();
    sendWord(syncPattern, 16, 24'h008101, early, st, tp);
    check(st == 1'b0 && hunting == 1'b1, "R5 three errors rejected at limit 2", int'(st), 0);
    errLimit = 2'd3; doArm();
    sendWord(syncPattern, 16, 24'h008101, early, st, tp);
    check(st == 1'b1, "R5 three errors accepted at limit 3", int'(st), 1);
    errLimit = 2'd0; doArm();
    sendWord(syncPattern, 16, 24'h000010, early, st, tp);
    check(st == 1'b0, "R5 one error rejected at limit 0", int'(st), 0);
  endtask

  task automatic t_stale_and_rearm();
    int early; bit st, tp;
    lenSel = 0; errLimit = 0; timeoutBits = 0; syncPattern = 24'h000FFF;
    doArm();
    sendWord(syncPattern, 12, 24'h0, early, st, tp);
    check(st == 1'b1, "R3 all-ones match", int'(st), 1);
    sendWord(syncPattern, 12, 24'h0, early, st, tp);
    check(early == 0 && st == 1'b0, "R7 no start before re-arm", early + int'(st), 0);
    repeat (5) @(negedge clk);
    check(lockFlag == 1'b1, "R12 lock holds", int'(lockFlag), 1);
    doArm();
    check(lockFlag == 1'b0, "R12 arm clears lock", int'(lockFlag), 0);
    sendBit(1'b1, st, tp);
    check(st == 1'b0, "R6 stale bits ignored", int'(st), 0);
    sendWord(syncPattern, 11, 24'h0, early, st, tp);
    check(early == 0 && st == 1'b1, "R6 start after N fresh bits", int'(st), 1);
  endtask

  task automatic t_watchdog();
    int early; bit st, tp;
    lenSel = 0; errLimit = 0; syncPattern = 24'h000FFF; timeoutBits = 16'd5;
    doArm();
    early = 0;
    for (int i = 1; i <= 5; i++) begin
      sendBit(1'b0, st, tp);
      if (i == 2) repeat (10) @(negedge clk);  // idle gap not counted
      if (i < 5) early += int'(st);
    end
    check(early == 0, "R9 no start before limit", early, 0);
    check(st && tp, "R9 timeout strobe", int'({st, tp}), 3);
    check(viaTimeout && !lockFlag && !hunting, "R9 timeout status",
          int'({viaTimeout, lockFlag, hunting}), 4);
    @(negedge clk);
    check(!timeoutPulse && !frameStart, "R8 timeout one cycle", int'(timeoutPulse), 0);
    timeoutBits = 0; doArm();
    check(viaTimeout == 1'b0, "R2 arm clears timeout status", int'(viaTimeout), 0);
    early = 0;
    for (int i = 0; i < 40; i++) begin sendBit(1'b0, st, tp); early += int'(st); end
    check(early == 0 && hunting, "R10 disabled watchdog silent", early, 0);
    timeoutBits = 16'd12; doArm();
    sendWord(syncPattern, 12, 24'h0, early, st, tp);
    check(st && !tp && lockFlag && !viaTimeout, "R11 match beats timeout",
          int'({st, tp, lockFlag, viaTimeout}), 10);
  endtask

  initial begin : watchdog_timer
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_lengths();
    t_tolerance();
    t_stale_and_rearm();
    t_watchdog();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule